// File: doc/BRIEF.md
# Bit Test-and-Modify Unit

This block executes the data part of a single-bit test-and-modify operation. It reads one selected bit of a destination operand and reports its inverse on the zero flag. It then returns the operand with that bit either inverted (change) or forced to zero (clear). The other four condition flags are passed through unchanged. Instruction decode sits upstream. The caller supplies the operation, the kind of target, a raw bit number (taken from an immediate or from a register), the register value, the memory address and the incoming flags.

A register target is a 32-bit word and is handled combinationally, with the bit number reduced modulo 32. A memory target is a single byte, with the bit number reduced modulo 8. For a memory target the unit runs a read-modify-write sequence over a simple request/response port. It issues a read request, waits for the returned byte, tests and modifies that byte, writes it back to the same address, and then pulses `done` with the resulting zero flag on `flags_out`.

Top module: `bit_tam_unit`

## Requirements
- R1: The zero flag (`flags_out[2]`) is 1 when the tested bit was 0 and 0 when it was 1. The test uses the operand value from before modification.
- R2: With `op_clear`=0 (change), the selected bit of the result is the inverse of the operand bit.
- R3: With `op_clear`=1 (clear), the selected bit of the result is 0.
- R4: For a register target, `reg_out` equals `reg_in` modified at bit index `bit_num` mod 32, with bit 0 as the least-significant bit, and every other bit is unchanged.
- R5: For a memory target, the written byte is the read byte modified at bit index `bit_num` mod 8, and every other bit is unchanged.
- R6: `flags_out` is {X,N,Z,V,C} with X at bit 4 and C at bit 0. X, N, V and C equal `flags_in[3]`, `flags_in[2]`, `flags_in[1]` and `flags_in[0]` respectively.
- R7: A memory request stays asserted, with an unchanged `mem_we`, until `mem_ready`. The address driven on `mem_addr_o` is the address captured at start and is held for the whole sequence.
- R8: The write (`mem_req`=1, `mem_we`=1) is issued only after `mem_rvalid` has returned the read byte. After the write is accepted, `done` pulses for exactly one cycle, with the memory test result on `flags_out[2]`.
- R9: After reset the unit is idle: `busy`, `done` and `mem_req` are 0.
- R10: `start` is ignored while `busy` is 1, and `start` with `tgt_mem`=0 launches no memory sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a memory sequence when `tgt_mem`=1 |
| op_clear | input | 1 | 0 = change (invert) the bit, 1 = clear it |
| tgt_mem | input | 1 | 1 = memory byte target, 0 = register target |
| bit_num | input | 6 | Raw bit number |
| reg_in | input | 32 | Register operand |
| mem_addr | input | 16 | Byte address for a memory target |
| flags_in | input | 4 | Incoming {X,N,V,C} |
| reg_out | output | 32 | Modified register value |
| flags_out | output | 5 | {X,N,Z,V,C} |
| busy | output | 1 | Memory sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a memory sequence |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata | output | 8 | Write-back byte |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |

## Verification
The assertions check the following on every cycle:
- a pending request holds steady until it is accepted;
- a write never appears unless read data has just returned;
- `done` never lasts two cycles;
- the register result differs from its operand in the selected bit only;
- a clear always leaves that bit at zero.

The bench scenarios have to show the rest:
- the actual Z polarity and the modulo reduction of out-of-range bit numbers, for both widths;
- the exact byte written back;
- that a second `start` during a sequence is ignored, under different memory latencies.

// File: rtl/btm_pkg.sv
// Package: shared types for the bit test-and-modify unit.
// Assumes: nothing beyond IEEE 1800-2017.
package btm_pkg;

    typedef enum logic {
        OP_CHANGE = 1'b0,
        OP_CLEAR  = 1'b1
    } btm_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ_REQ,
        S_READ_WAIT,
        S_WRITE_REQ,
        S_DONE
    } btm_state_e;

endpackage

// File: rtl/btm_bit_alu.sv
// Module: btm_bit_alu
// Tests bit idx of opnd, reports its inverse on z, and returns the operand
// with that bit inverted (change) or forced to 0 (clear).
// Assumes: idx is already reduced to the operand width.
module btm_bit_alu #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  opnd,
    input  logic [IW-1:0] idx,
    input  btm_pkg::btm_op_e op,
    output logic [W-1:0]  res,
    output logic          z
);
    import btm_pkg::*;

    logic [W-1:0] mask;

    // Build the one-hot mask, test the bit and apply the operation.
    always_comb begin
        mask      = '0;
        mask[idx] = 1'b1;
        z         = ~opnd[idx];
        res       = (op == OP_CLEAR) ? (opnd & ~mask) : (opnd ^ mask);
    end

endmodule

// File: rtl/btm_mem_seq.sv
// Module: btm_mem_seq
// Sequencer for a byte read-modify-write. It captures the operation, the
// reduced bit index and the address at start, reads one byte and holds it
// for the modify logic. It then writes the modified byte back and pulses done.
// Assumes: the memory answers each read with exactly one mem_rvalid, after
// it has accepted the read request.
module btm_mem_seq #(
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int BN_W  = 6,
    parameter int IW    = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  btm_pkg::btm_op_e op_in,
    input  logic [BN_W-1:0]  bit_in,
    input  logic [AW-1:0]    addr_in,
    input  logic             mem_ready,
    input  logic             mem_rvalid,
    input  logic [DW-1:0]    mem_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr_o,
    output logic [DW-1:0]    byte_q,
    output logic [IW-1:0]    idx_q,
    output btm_pkg::btm_op_e op_q,
    output logic             busy,
    output logic             done
);
    import btm_pkg::*;

    btm_state_e   state_q;
    logic [AW-1:0] addr_q;

    // State register and capture of the operands and the read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
            byte_q  <= '0;
            idx_q   <= '0;
            op_q    <= OP_CHANGE;
        end else begin
            case (state_q)
                S_IDLE: if (launch) begin
                    state_q <= S_READ_REQ;
                    addr_q  <= addr_in;
                    op_q    <= op_in;
                    idx_q   <= IW'(bit_in % BN_W'(DW));
                end
                S_READ_REQ:  if (mem_ready) state_q <= S_READ_WAIT;
                S_READ_WAIT: if (mem_rvalid) begin
                    byte_q  <= mem_rdata;
                    state_q <= S_WRITE_REQ;
                end
                S_WRITE_REQ: if (mem_ready) state_q <= S_DONE;
                S_DONE:      state_q <= S_IDLE;
                default:     state_q <= S_IDLE;
            endcase
        end
    end

    // Decode the memory port and status from the state.
    always_comb begin
        mem_req    = (state_q == S_READ_REQ) || (state_q == S_WRITE_REQ);
        mem_we     = (state_q == S_WRITE_REQ);
        mem_addr_o = addr_q;
        busy       = (state_q != S_IDLE);
        done       = (state_q == S_DONE);
    end

    // R7: an unaccepted request is held with the same direction and address.
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr_o)));

    // R8: a write starts only on the cycle after read data returned.
    p_write_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_rvalid));

    // R8: done is a single-cycle pulse.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/bit_tam_unit.sv
// Module: bit_tam_unit (top)
// Single-bit test-and-modify. The register path is combinational (32-bit,
// bit number mod 32). The memory path is a byte read-modify-write (bit number
// mod 8). Z carries the inverse of the tested bit. X, N, V and C pass through.
// Assumes: flags_in = {X,N,V,C}; flags_out = {X,N,Z,V,C}.
module bit_tam_unit #(
    parameter int REG_W = 32,
    parameter int MEM_W = 8,
    parameter int AW    = 16,
    parameter int BN_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_clear,
    input  logic             tgt_mem,
    input  logic [BN_W-1:0]  bit_num,
    input  logic [REG_W-1:0] reg_in,
    input  logic [AW-1:0]    mem_addr,
    input  logic [3:0]       flags_in,
    output logic [REG_W-1:0] reg_out,
    output logic [4:0]       flags_out,
    output logic             busy,
    output logic             done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr_o,
    output logic [MEM_W-1:0] mem_wdata,
    input  logic             mem_ready,
    input  logic             mem_rvalid,
    input  logic [MEM_W-1:0] mem_rdata
);
    import btm_pkg::*;

    localparam int REG_IW = $clog2(REG_W);
    localparam int MEM_IW = $clog2(MEM_W);

    btm_op_e           op_in;
    btm_op_e           op_q;
    logic [REG_IW-1:0] reg_idx;
    logic [MEM_IW-1:0] mem_idx;
    logic [MEM_W-1:0]  byte_q;
    logic              z_reg;
    logic              z_mem;
    logic              launch;

    // Decode the operation, reduce the register bit index and gate the launch.
    always_comb begin
        op_in   = op_clear ? OP_CLEAR : OP_CHANGE;
        reg_idx = REG_IW'(bit_num % BN_W'(REG_W));
        launch  = start && tgt_mem && !busy;
    end

    btm_bit_alu #(.W(REG_W)) i_reg_alu (
        .opnd (reg_in),
        .idx  (reg_idx),
        .op   (op_in),
        .res  (reg_out),
        .z    (z_reg)
    );

    btm_mem_seq #(.AW(AW), .DW(MEM_W), .BN_W(BN_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .op_in      (op_in),
        .bit_in     (bit_num),
        .addr_in    (mem_addr),
        .mem_ready  (mem_ready),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr_o (mem_addr_o),
        .byte_q     (byte_q),
        .idx_q      (mem_idx),
        .op_q       (op_q),
        .busy       (busy),
        .done       (done)
    );

    btm_bit_alu #(.W(MEM_W)) i_mem_alu (
        .opnd (byte_q),
        .idx  (mem_idx),
        .op   (op_q),
        .res  (mem_wdata),
        .z    (z_mem)
    );

    // Merge Z into the passed-through flags; the memory result shows on done.
    always_comb begin
        flags_out = {flags_in[3:2], (done ? z_mem : z_reg), flags_in[1:0]};
    end

    // R4: the register result differs from its operand only at the selected bit.
    p_only_sel_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (((reg_out ^ reg_in) & ~(REG_W'(1) << reg_idx)) == '0));

    // R3: a clear on a register always leaves the selected bit at zero.
    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_clear |-> (reg_out[reg_idx] == 1'b0));

    // R10: a new launch cannot occur while a sequence is running.
    p_no_relaunch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

// File: tb/test_bit_tam_unit.sv
`timescale 1ns/1ps
module test_bit_tam_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_clear = 1'b0;
    logic        tgt_mem = 1'b0;
    logic [5:0]  bit_num = '0;
    logic [31:0] reg_in = '0;
    logic [15:0] mem_addr = '0;
    logic [3:0]  flags_in = '0;
    logic [31:0] reg_out;
    logic [4:0]  flags_out;
    logic        busy, done, mem_req, mem_we;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata;
    logic        mem_ready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bit_tam_unit i_bit_tam_unit (
        .clk, .rst_n, .start, .op_clear, .tgt_mem, .bit_num, .reg_in,
        .mem_addr, .flags_in, .reg_out, .flags_out, .busy, .done, .mem_req,
        .mem_we, .mem_addr_o, .mem_wdata, .mem_ready, .mem_rvalid, .mem_rdata
    );

    typedef struct packed {
        logic        op;
        logic [5:0]  bn;
        logic [31:0] val;
        logic [3:0]  flg;
        logic [31:0] exp_val;
        logic        exp_z;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 6'd4,  32'h0000_00AA, 4'b1010, 32'h0000_00BA, 1'b1},
        '{1'b1, 6'd4,  32'h0000_00FA, 4'b0101, 32'h0000_00EA, 1'b0},
        '{1'b0, 6'd31, 32'h0000_0000, 4'b1111, 32'h8000_0000, 1'b1},
        '{1'b1, 6'd0,  32'hFFFF_FFFF, 4'b0000, 32'hFFFF_FFFE, 1'b0},
        '{1'b0, 6'd36, 32'h0000_0010, 4'b1100, 32'h0000_0000, 1'b0},
        '{1'b1, 6'd63, 32'h7FFF_FFFF, 4'b0011, 32'h7FFF_FFFF, 1'b1},
        '{1'b0, 6'd0,  32'h0000_0001, 4'b1001, 32'h0000_0000, 1'b0},
        '{1'b1, 6'd17, 32'h0002_0000, 4'b0110, 32'h0000_0000, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_mem(input logic op, input logic [5:0] bn, input logic [15:0] addr,
                           input logic [7:0] rd, input int dly, input logic [3:0] flg,
                           input logic [7:0] exp_w, input logic exp_z, input logic poke);
        @(negedge clk);
        start = 1'b1; tgt_mem = 1'b1; op_clear = op; bit_num = bn;
        mem_addr = addr; flags_in = flg;
        @(negedge clk);
        start = 1'b0;
        chk("R7 read req", {mem_req, mem_we}, 2'b10);
        chk("R7 read addr", mem_addr_o, addr);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk("R7 req held", {mem_req, mem_we}, 2'b10);
        end
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        for (int i = 0; i < dly; i++) begin
            chk("R8 no write before data", mem_req, 1'b0);
            if (poke && i == 0) begin
                start = 1'b1; mem_addr = addr + 16'h0101;
            end
            @(negedge clk);
            start = 1'b0;
        end
        mem_rvalid = 1'b1; mem_rdata = rd;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = 8'h00;
        chk("R8 write req", {mem_req, mem_we}, 2'b11);
        chk("R5 write data", mem_wdata, exp_w);
        chk("R7 write addr", mem_addr_o, addr);
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        chk("R8 done", done, 1'b1);
        chk("R1 R6 mem flags", flags_out, {flg[3:2], exp_z, flg[1:0]});
        @(negedge clk);
        chk("R8 done one cycle", {done, busy}, 2'b00);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset", {busy, done, mem_req}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after reset", {busy, done, mem_req}, 3'b000);

        // Register vectors: R1 R2 R3 R4 R6
        foreach (VEC[k]) begin
            @(negedge clk);
            tgt_mem = 1'b0; op_clear = VEC[k].op; bit_num = VEC[k].bn;
            reg_in = VEC[k].val; flags_in = VEC[k].flg;
            #1;
            chk("R2 R3 R4 reg result", reg_out, VEC[k].exp_val);
            chk("R1 R6 reg flags", flags_out,
                {VEC[k].flg[3:2], VEC[k].exp_z, VEC[k].flg[1:0]});
        end

        // R10: start with a register target launches nothing
        @(negedge clk);
        start = 1'b1; tgt_mem = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk("R10 reg start no seq", {busy, mem_req}, 2'b00);

        // Memory sequences: R5 R7 R8 R1
        run_mem(1'b0, 6'd4,  16'h1234, 8'b1010_1010, 0, 4'b1010, 8'b1011_1010, 1'b1, 1'b0);
        run_mem(1'b1, 6'd12, 16'hBEEF, 8'b1111_1010, 2, 4'b0101, 8'b1110_1010, 1'b0, 1'b1);
        run_mem(1'b0, 6'd63, 16'h0001, 8'h00,        3, 4'b1111, 8'h80,        1'b1, 1'b1);
        run_mem(1'b1, 6'd0,  16'hFFFF, 8'hFE,        1, 4'b0000, 8'hFE,        1'b1, 1'b0);

        // R9: reset in the middle of a sequence returns to idle
        @(negedge clk);
        start = 1'b1; tgt_mem = 1'b1;
        @(negedge clk);
        start = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk("R9 mid-sequence reset", {busy, done, mem_req}, 3'b000);
        rst_n = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule